// File: doc/BRIEF.md
# Asymmetric Input Debouncer with Edge Interrupt

This block debounces a set of slow external input pins. Each pin has its own engine. The engine stays idle until an edge event (a start pulse) arrives for its pin. From then on it compares the raw pin level against its stored, debounced level once per check tick. Every check where the raw level still equals the stored level reloads a countdown. Every check where the two differ counts it down. When the countdown runs out, the engine commits the raw level as the new debounced level, drops back to idle, and emits two pulses. One is a polarity-toggle request, so that the external edge detector can arm itself for the opposite edge. The other is an interrupt pulse, but only when the committed edge qualifies.

The qualification time is set separately for each direction. The rising count is the low-to-high time divided by the check period, and the falling count is the high-to-low time divided by the check period. A pin configured active-low interrupts on a committed low level. Any other pin interrupts on a committed high level. Double-edge mode makes every commit interrupt. The check tick is produced outside the block and is shared by all pins.

All ports are plain control and status pins. No data stream passes through the block, so no valid/ready handshake and no back-pressure apply.

Top module: `deb_asym_engine`

## Requirements
- R1: In the first clock cycle after reset is released, each pin loads its debounced level from its raw input. After reset, busy, irq_pulse and tog_req are all 0.
- R2: A start pulse on an idle pin makes busy 1 from the next cycle. While a pin is idle, check ticks and raw-level changes leave its debounced level unchanged.
- R3: A rising edge commits on the LH_CNT-th consecutive mismatching tick after the start, where LH_CNT = LH_MS / CHECK_MS. At the same clock edge that commits, the debounced level becomes 1 and busy falls.
- R4: A falling edge commits on the HL_CNT-th consecutive mismatching tick, where HL_CNT = HL_MS / CHECK_MS. HL_CNT is independent of LH_CNT.
- R5: A tick at which the raw level equals the debounced level reloads the countdown. A mismatch run that is broken by a matching tick therefore needs a full count again.
- R6: On a commit, irq_pulse fires if either of two conditions holds: act_low = 1 and the new level is 0, or act_low = 0 and the new level is 1. irq_pulse also fires whenever dbl_edge = 1. In all other cases it stays 0.
- R7: tog_req is 1 for exactly one cycle after every commit. irq_pulse, when it fires, is 1 in that same single cycle.
- R8: A start pulse while a pin is busy is ignored. It neither restarts nor reloads the countdown.
- R9: pin_level equals the debounced level XOR act_low.
- R10: Pins are independent. Activity on one pin never changes another pin's outputs.
- R11: A tick sampled in the same cycle as an accepted start does not count as a check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | NUM_PINS | Raw pin levels, synchronous to clk |
| start_in | input | NUM_PINS | Per-pin edge event that starts a debounce |
| tick_in | input | 1 | Check tick, one cycle wide, shared by all pins |
| act_low_in | input | NUM_PINS | Pin is active-low |
| dbl_edge_in | input | NUM_PINS | Interrupt on both committed edges |
| deb_level | output | NUM_PINS | Debounced level |
| pin_level | output | NUM_PINS | Reported level, debounced level XOR act_low |
| irq_pulse | output | NUM_PINS | One-cycle interrupt on a qualifying commit |
| tog_req | output | NUM_PINS | One-cycle request to flip the pin's edge polarity |
| busy | output | NUM_PINS | Debounce in progress |

## Verification
The bench instantiates the block with unequal rising and falling counts (3 and 2). This lets a pin that used the wrong reload value commit one tick early or late, which the bench detects. Clean runs of mismatching ticks are mixed with runs broken by a matching tick, which separates reload-on-match from a plain countdown. A second start while busy separates an ignored start from a restart. Commits are driven in both directions under active-high, active-low and double-edge settings, so each qualification term is tried with an interrupt expected and with none expected. A scoreboard pairs every toggle request with its expected interrupt value and level.

// File: rtl/deb_pkg.sv
package deb_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_CHECK = 2'd2
  } deb_state_e;
endpackage

// File: rtl/deb_reload_sel.sv
module deb_reload_sel #(
  parameter int CW     = 2,
  parameter int LH_CNT = 2,
  parameter int HL_CNT = 2
) (
  input  logic          level_i,
  output logic [CW-1:0] reload_o
);
  // Count for leaving the given level: a high level waits for a fall.
  always_comb begin
    reload_o = level_i ? CW'(HL_CNT) : CW'(LH_CNT);
  end
endmodule

// File: rtl/deb_irq_qual.sv
module deb_irq_qual (
  input  logic new_level_i,
  input  logic act_low_i,
  input  logic dbl_edge_i,
  output logic fire_o
);
  always_comb begin
    fire_o = dbl_edge_i | (new_level_i ^ act_low_i);
  end
endmodule

// File: rtl/deb_lane.sv
module deb_lane
  import deb_pkg::*;
#(
  parameter int CW     = 2,
  parameter int LH_CNT = 2,
  parameter int HL_CNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic start_i,
  input  logic tick_i,
  input  logic act_low_i,
  input  logic dbl_edge_i,
  output logic deb_o,
  output logic busy_o,
  output logic irq_o,
  output logic tog_o
);
  deb_state_e    st_q;
  logic          deb_q;
  logic [CW-1:0] cnt_q;
  logic          irq_q;
  logic          tog_q;

  logic [CW-1:0] hold_rld;
  logic [CW-1:0] new_rld;
  logic          fire;
  logic          mismatch;
  logic          last_chk;

  deb_reload_sel #(.CW(CW), .LH_CNT(LH_CNT), .HL_CNT(HL_CNT)) u_hold_rld (
    .level_i (deb_q),
    .reload_o(hold_rld)
  );

  deb_reload_sel #(.CW(CW), .LH_CNT(LH_CNT), .HL_CNT(HL_CNT)) u_new_rld (
    .level_i (raw_i),
    .reload_o(new_rld)
  );

  deb_irq_qual u_qual (
    .new_level_i(raw_i),
    .act_low_i  (act_low_i),
    .dbl_edge_i (dbl_edge_i),
    .fire_o     (fire)
  );

  always_comb begin
    mismatch = raw_i != deb_q;
    last_chk = cnt_q == CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_INIT;
      deb_q <= 1'b0;
      cnt_q <= CW'(LH_CNT);
      irq_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      tog_q <= 1'b0;
      unique case (st_q)
        ST_INIT: begin
          deb_q <= raw_i;
          cnt_q <= new_rld;
          st_q  <= ST_IDLE;
        end
        ST_IDLE: begin
          if (start_i) st_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (tick_i) begin
            if (!mismatch) begin
              cnt_q <= hold_rld;
            end else if (last_chk) begin
              deb_q <= raw_i;
              cnt_q <= new_rld;
              irq_q <= fire;
              tog_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q - CW'(1);
            end
          end
        end
        default: st_q <= ST_INIT;
      endcase
    end
  end

  assign deb_o  = deb_q;
  assign busy_o = st_q == ST_CHECK;
  assign irq_o  = irq_q;
  assign tog_o  = tog_q;

  // R7: interrupt lasts one cycle and only accompanies a toggle request
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r7_irq_with_tog: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> tog_q);
  // R3: busy only ends on a check tick
  a_r3_commit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_i));
  // R8: a start while busy leaves the countdown alone
  a_r8_start_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !tick_i) |=> (cnt_q == $past(cnt_q)));
  // R2: an idle pin without a start keeps its level
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> $stable(deb_q));
  // R5: countdown never sits at zero
  a_r5_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  // R6: double-edge commits always interrupt
  a_r6_dbl_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_q && $past(dbl_edge_i)) |-> irq_q);
endmodule

// File: rtl/deb_asym_engine.sv
module deb_asym_engine #(
  parameter int NUM_PINS = 4,
  parameter int CHECK_MS = 1,
  parameter int LH_MS    = 2,
  parameter int HL_MS    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] raw_in,
  input  logic [NUM_PINS-1:0] start_in,
  input  logic                tick_in,
  input  logic [NUM_PINS-1:0] act_low_in,
  input  logic [NUM_PINS-1:0] dbl_edge_in,
  output logic [NUM_PINS-1:0] deb_level,
  output logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] irq_pulse,
  output logic [NUM_PINS-1:0] tog_req,
  output logic [NUM_PINS-1:0] busy
);
  localparam int LH_CNT  = (LH_MS / CHECK_MS < 1) ? 1 : LH_MS / CHECK_MS;
  localparam int HL_CNT  = (HL_MS / CHECK_MS < 1) ? 1 : HL_MS / CHECK_MS;
  localparam int MAX_CNT = (LH_CNT > HL_CNT) ? LH_CNT : HL_CNT;
  localparam int CW      = $clog2(MAX_CNT + 1);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    deb_lane #(.CW(CW), .LH_CNT(LH_CNT), .HL_CNT(HL_CNT)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (raw_in[p]),
      .start_i   (start_in[p]),
      .tick_i    (tick_in),
      .act_low_i (act_low_in[p]),
      .dbl_edge_i(dbl_edge_in[p]),
      .deb_o     (deb_level[p]),
      .busy_o    (busy[p]),
      .irq_o     (irq_pulse[p]),
      .tog_o     (tog_req[p])
    );
  end

  assign pin_level = deb_level ^ act_low_in;
endmodule

// File: tb/deb_asym_engine_tb.sv
`timescale 1ns/1ps
module deb_asym_engine_tb_top;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] raw_in = '0;
  logic [NP-1:0] start_in = '0;
  logic          tick_in = 1'b0;
  logic [NP-1:0] act_low_in = '0;
  logic [NP-1:0] dbl_edge_in = '0;
  logic [NP-1:0] deb_level, pin_level, irq_pulse, tog_req, busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int pin;
    bit irq;
    bit lvl;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  deb_asym_engine #(.NUM_PINS(NP), .CHECK_MS(1), .LH_MS(3), .HL_MS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .start_in(start_in),
    .tick_in(tick_in), .act_low_in(act_low_in), .dbl_edge_in(dbl_edge_in),
    .deb_level(deb_level), .pin_level(pin_level), .irq_pulse(irq_pulse),
    .tog_req(tog_req), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick();
    tick_in = 1'b1;
    step();
    tick_in = 1'b0;
  endtask

  task automatic start(input int p);
    start_in[p] = 1'b1;
    step();
    start_in[p] = 1'b0;
  endtask

  task automatic expect_commit(input int p, input bit irq, input bit lvl);
    exp_t e;
    e.pin = p; e.irq = irq; e.lvl = lvl;
    exp_q.push_back(e);
  endtask

  // Monitor: every toggle request is matched against the scoreboard (R6, R7)
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (irq_pulse[p] && !tog_req[p]) check("R7 irq without toggle", 1, 0);
        if (tog_req[p]) begin
          if (exp_q.size() == 0) begin
            check("R7 unexpected commit", p, -1);
          end else begin
            e = exp_q.pop_front();
            check("R10 commit pin", p, e.pin);
            check("R6 irq on commit", int'(irq_pulse[p]), int'(e.irq));
            check("R3 R4 committed level", int'(deb_level[p]), int'(e.lvl));
          end
        end
      end
    end
  end

  initial begin
    raw_in = 2'b10;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    step();
    check("R1 level loaded from raw", int'(deb_level), 2);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 irq after reset", int'(irq_pulse), 0);
    check("R1 toggle after reset", int'(tog_req), 0);

    // R2: idle pin ignores ticks
    raw_in[0] = 1'b1;
    tick(); tick(); tick();
    check("R2 idle holds level", int'(deb_level[0]), 0);
    check("R2 idle not busy", int'(busy[0]), 0);

    // R11: start with a same-cycle tick; R3 rising needs 3 ticks
    start_in[0] = 1'b1; tick_in = 1'b1;
    step();
    start_in[0] = 1'b0; tick_in = 1'b0;
    check("R2 busy after start", int'(busy[0]), 1);
    tick(); tick();
    check("R11 R3 not yet committed", int'(deb_level[0]), 0);
    expect_commit(0, 1'b1, 1'b1);
    tick();
    check("R3 rise committed", int'(deb_level[0]), 1);
    check("R3 busy falls", int'(busy[0]), 0);
    check("R9 active-high report", int'(pin_level[0]), 1);
    step();
    check("R7 irq single cycle", int'(irq_pulse[0]), 0);
    check("R7 toggle single cycle", int'(tog_req[0]), 0);

    // R4 falling, active-low pin: two ticks
    act_low_in[0] = 1'b1;
    #1;
    check("R9 active-low report", int'(pin_level[0]), 0);
    raw_in[0] = 1'b0;
    start(0);
    tick();
    check("R4 fall not yet", int'(deb_level[0]), 1);
    expect_commit(0, 1'b1, 1'b0);
    tick();
    check("R4 fall committed", int'(deb_level[0]), 0);

    // R5: matching tick reloads countdown
    act_low_in[0] = 1'b0;
    raw_in[0] = 1'b1;
    start(0);
    tick(); tick();
    raw_in[0] = 1'b0;
    tick();
    raw_in[0] = 1'b1;
    tick(); tick();
    check("R5 reload delays commit", int'(deb_level[0]), 0);
    expect_commit(0, 1'b1, 1'b1);
    tick();
    check("R5 commit after full count", int'(deb_level[0]), 1);

    // R6: active-high falling edge, no interrupt
    raw_in[0] = 1'b0;
    start(0);
    expect_commit(0, 1'b0, 1'b0);
    tick(); tick();
    step();

    // R6: double-edge, both directions interrupt
    dbl_edge_in[0] = 1'b1;
    raw_in[0] = 1'b1;
    start(0);
    expect_commit(0, 1'b1, 1'b1);
    tick(); tick(); tick();
    raw_in[0] = 1'b0;
    start(0);
    expect_commit(0, 1'b1, 1'b0);
    tick(); tick();
    step();
    dbl_edge_in[0] = 1'b0;

    // R8: second start while busy does not restart
    raw_in[0] = 1'b1;
    start(0);
    tick();
    start(0);
    tick();
    check("R8 still busy", int'(busy[0]), 1);
    check("R8 not yet", int'(deb_level[0]), 0);
    expect_commit(0, 1'b1, 1'b1);
    tick();
    check("R8 commit on original schedule", int'(deb_level[0]), 1);

    // R10: pin 1 falls active-low while pin 0 sits idle with differing raw
    raw_in[0] = 1'b0;
    act_low_in[1] = 1'b1;
    raw_in[1] = 1'b0;
    start(1);
    check("R10 other pin idle", int'(busy[0]), 0);
    tick();
    expect_commit(1, 1'b1, 1'b0);
    tick();
    check("R10 pin1 committed", int'(deb_level[1]), 0);
    check("R10 pin0 untouched", int'(deb_level[0]), 1);
    check("R9 pin1 active-low report", int'(pin_level[1]), 1);
    step(); step();
    check("R7 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule